// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Interrupt Detection

This block is a memory-mapped general-purpose I/O port with eight pins, reached through a simple APB-style register bus. Each pin can be an input or an output, chosen by one bit in a direction register. Pin values are reached through a data window in which the word address itself carries a per-pin mask. Software can therefore set, clear or sample a single pin with one bus access, and no read-modify-write sequence is needed.

Every pin also has an interrupt detector. A pin can be set to level detection, active high or active low. It can instead be set to edge detection on the rising edge, on the falling edge, or on both edges. Edge events are latched until software clears them through a write-one-to-clear register. Level status follows the live pin. A per-pin enable forms the masked status, and the OR of the masked bits drives one combined interrupt line.

Pad inputs pass through a two-flop synchroniser before they are read or examined for events. An edge is found by comparing the synchronised sample with the sample taken one cycle earlier.

Top module: `gpio8_irq`

## Requirements
- R1: After reset every register reads 0, so all pins are inputs and all interrupts are disabled. pad_oe and irq_out are 0. Reads of any unmapped offset (0x420 and above) return 0.
- R2: The direction register at offset 0x400 drives pad_oe bit for bit. A 1 makes the pin an output and a 0 makes it an input.
- R3: A write to offset 0x000–0x3FC updates only those output pins whose mask bit is 1. The mask bit for pin n is address bit n+2. pad_out shows the stored data value.
- R4: A read from the data window returns 0 for every pin whose mask bit is 0. A masked pin returns the stored data value when it is an output and its synchronised pad level when it is an input.
- R5: A data write to a pin set as input stores nothing. After the pin is switched to output, pad_out still shows the value it held before that write.
- R6: A sense bit of 1 (offset 0x404) selects level detection. A polarity bit (offset 0x40C) of 1 means active high and 0 means active low. Level raw status follows the live synchronised level, and the clear register has no effect on it.
- R7: With the sense bit at 0 and the both-edges bit at 0, a polarity bit of 1 latches raw status on a rising edge and a 0 latches it on a falling edge.
- R8: With the sense bit at 0 and the both-edges bit (offset 0x408) at 1, either edge latches raw status, whatever the polarity bit holds.
- R9: Writing 1 to a bit of the clear register (offset 0x41C) clears that pin's latched edge status. A 0 bit has no effect. If a new edge arrives in the same cycle as the clear, the edge wins.
- R10: Raw status reads at offset 0x414. Masked status at offset 0x418 equals raw status AND the enable register (offset 0x410). irq_out is the OR of the masked bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 10 | Word address, byte address bits 11:2 |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, valid while psel is high |
| pad_in | input | 8 | Asynchronous pin levels from the pads |
| pad_out | output | 8 | Output values to the pads |
| pad_oe | output | 8 | Per-pin output enable |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench aims at the address-mask window. It writes and reads through random masks with mixed directions, so a design that ignored the mask or wrote input pins would corrupt pad_out or return stray 1s on unmasked bits. It also toggles pins under random mixes of level, single-edge and both-edge settings. A design that let polarity leak into both-edge mode would miss half the events, and one that latched level status would keep an interrupt raised after the pin returned to idle. Directed cases confirm that a write of 0 to the clear register leaves status untouched, and that clearing a level-mode pin does not drop its status.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;
  localparam int unsigned PINS = 8;
  localparam int unsigned AW   = 12;

  typedef logic [PINS-1:0] pinvec_t;

  // Control registers occupy byte offsets 0x400..0x41C; index is address bits 4:2
  typedef enum logic [2:0] {
    SEL_DIR    = 3'd0,
    SEL_SENSE  = 3'd1,
    SEL_BOTH   = 3'd2,
    SEL_POL    = 3'd3,
    SEL_EN     = 3'd4,
    SEL_RAW    = 3'd5,
    SEL_MASKED = 3'd6,
    SEL_CLR    = 3'd7
  } regsel_e;

  localparam logic [AW-1:0] CTRL_BASE = 12'h400;
endpackage

// File: rtl/gpio8_sync.sv
module gpio8_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_async;
      stab_q <= meta_q;
    end
  end

  assign q_sync = stab_q;
endmodule

// File: rtl/gpio8_irq_detect.sv
module gpio8_irq_detect #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] sense,
  input  logic [W-1:0] both,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr,
  output logic [W-1:0] raw
);
  logic [W-1:0] prev_q;
  logic [W-1:0] latch_q;
  logic [W-1:0] latch_d;
  logic [W-1:0] edge_evt;
  logic [W-1:0] level_hit;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise;
    logic fall;
    assign rise = smp[i] & ~prev_q[i];
    assign fall = ~smp[i] & prev_q[i];
    always_comb begin
      if (both[i]) edge_evt[i] = rise | fall;
      else if (pol[i]) edge_evt[i] = rise;
      else edge_evt[i] = fall;
    end
    assign level_hit[i] = pol[i] ? smp[i] : ~smp[i];
  end

  // next state: new edge has priority over a clear in the same cycle
  always_comb begin
    latch_d = (latch_q & ~clr) | (edge_evt & ~sense);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= smp;
      latch_q <= latch_d;
    end
  end

  assign raw = (sense & level_hit) | (~sense & latch_q);

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(edge_evt & ~sense)) |=> ((latch_q & $past(edge_evt & ~sense)) == $past(edge_evt & ~sense))); // R7
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((|clr) && !(|edge_evt)) |=> ((latch_q & $past(clr)) == '0)); // R9
endmodule

// File: rtl/gpio8_irq.sv
module gpio8_irq
  import gpio8_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [11:2]          paddr,
  input  logic [PINS-1:0]      pwdata,
  output logic [PINS-1:0]      prdata,
  input  logic [PINS-1:0]      pad_in,
  output logic [PINS-1:0]      pad_out,
  output logic [PINS-1:0]      pad_oe,
  output logic                 irq_out
);
  pinvec_t dir_q,   dir_d;
  pinvec_t data_q,  data_d;
  pinvec_t sense_q, sense_d;
  pinvec_t both_q,  both_d;
  pinvec_t pol_q,   pol_d;
  pinvec_t en_q,    en_d;
  pinvec_t clr;
  pinvec_t smp;
  pinvec_t raw;
  pinvec_t masked;
  pinvec_t mask;
  pinvec_t wr_mask;
  regsel_e sel;
  logic    wr_en;
  logic    ctrl_hit;
  logic    data_hit;

  assign wr_en    = psel & penable & pwrite;
  assign ctrl_hit = (paddr[11:5] == CTRL_BASE[11:5]);
  assign data_hit = (paddr[11:10] == 2'b00);
  assign sel      = regsel_e'(paddr[4:2]);
  assign mask     = paddr[9:2];
  assign wr_mask  = mask & dir_q;

  gpio8_sync #(.W(PINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pad_in),
    .q_sync  (smp)
  );

  gpio8_irq_detect #(.W(PINS)) u_det (
    .clk   (clk),
    .rst_n (rst_n),
    .smp   (smp),
    .sense (sense_q),
    .both  (both_q),
    .pol   (pol_q),
    .clr   (clr),
    .raw   (raw)
  );

  // next-state logic for the register file
  always_comb begin
    dir_d   = dir_q;
    data_d  = data_q;
    sense_d = sense_q;
    both_d  = both_q;
    pol_d   = pol_q;
    en_d    = en_q;
    clr     = '0;
    if (wr_en && ctrl_hit) begin
      case (sel)
        SEL_DIR:   dir_d   = pwdata;
        SEL_SENSE: sense_d = pwdata;
        SEL_BOTH:  both_d  = pwdata;
        SEL_POL:   pol_d   = pwdata;
        SEL_EN:    en_d    = pwdata;
        SEL_CLR:   clr     = pwdata;
        default:   ;
      endcase
    end
    if (wr_en && data_hit) begin
      data_d = (data_q & ~wr_mask) | (pwdata & wr_mask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      data_q  <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      en_q    <= '0;
    end else begin
      dir_q   <= dir_d;
      data_q  <= data_d;
      sense_q <= sense_d;
      both_q  <= both_d;
      pol_q   <= pol_d;
      en_q    <= en_d;
    end
  end

  assign masked = raw & en_q;

  // read path
  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (data_hit) begin
        prdata = mask & ((dir_q & data_q) | (~dir_q & smp));
      end else if (ctrl_hit) begin
        case (sel)
          SEL_DIR:    prdata = dir_q;
          SEL_SENSE:  prdata = sense_q;
          SEL_BOTH:   prdata = both_q;
          SEL_POL:    prdata = pol_q;
          SEL_EN:     prdata = en_q;
          SEL_RAW:    prdata = raw;
          SEL_MASKED: prdata = masked;
          default:    prdata = '0;
        endcase
      end
    end
  end

  assign pad_out = data_q;
  assign pad_oe  = dir_q;
  assign irq_out = |masked;

  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ctrl_hit && sel == SEL_DIR) |=> (pad_oe == $past(pwdata))); // R2
  AST_INPUT_PIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && data_hit) |=> (((pad_out ^ $past(pad_out)) & ~$past(dir_q & mask)) == '0)); // R5
  AST_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_out); // R10
endmodule

// File: tb/sim_gpio8_irq.sv
module sim_gpio8_irq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       psel, penable, pwrite;
  logic [11:2] paddr;
  logic [7:0] pwdata, prdata, pad_in, pad_out, pad_oe;
  logic       irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [7:0] m_dir, m_data, m_sense, m_both, m_pol, m_en, m_latch, m_pad;

  always #2 clk = ~clk;

  gpio8_irq u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
  );

  function automatic logic [7:0] f_raw();
    return (m_sense & (m_pol & m_pad | ~m_pol & ~m_pad)) | (~m_sense & m_latch);
  endfunction

  function automatic logic [7:0] f_data_read(input logic [11:0] a);
    return a[9:2] & ((m_dir & m_data) | (~m_dir & m_pad));
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    psel = 1; pwrite = 1; penable = 0; paddr = a[11:2]; pwdata = d;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
    if (a[11:10] == 2'b00)
      m_data = (m_data & ~(a[9:2] & m_dir)) | (d & a[9:2] & m_dir);
    else case (a)
      12'h400: m_dir = d;
      12'h404: m_sense = d;
      12'h408: m_both = d;
      12'h40C: m_pol = d;
      12'h410: m_en = d;
      12'h41C: m_latch = m_latch & ~d;
      default: ;
    endcase
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    psel = 1; pwrite = 0; penable = 0; paddr = a[11:2];
    @(negedge clk);
    penable = 1;
    #1 d = prdata;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic set_pad(input logic [7:0] v);
    logic [7:0] rise, fall, ev;
    rise = v & ~m_pad;
    fall = ~v & m_pad;
    ev = (m_both & (rise | fall)) | (~m_both & m_pol & rise) | (~m_both & ~m_pol & fall);
    m_latch = m_latch | (ev & ~m_sense);
    m_pad = v;
    @(negedge clk);
    pad_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_irq(input string req);
    logic [7:0] r;
    bus_rd(12'h414, r); check(req, r, f_raw());
    bus_rd(12'h418, r); check(req, r, f_raw() & m_en);
    check(req, {7'd0, irq_out}, {7'd0, |(f_raw() & m_en)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [11:0] a;
    void'($urandom(32'd1234));
    m_dir = 0; m_data = 0; m_sense = 0; m_both = 0; m_pol = 0; m_en = 0; m_latch = 0; m_pad = 0;
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = 0; pad_in = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 irq", {7'd0, irq_out}, 8'h00);
    for (int k = 0; k < 8; k++) begin
      bus_rd(12'h400 + 12'(4 * k), r); check("R1 reg", r, 8'h00);
    end
    bus_rd(12'h420, r); check("R1 unmapped", r, 8'h00);
    bus_rd(12'h800, r); check("R1 unmapped", r, 8'h00);

    // R2 direction
    bus_wr(12'h400, 8'hA5); check("R2 pad_oe", pad_oe, 8'hA5);
    bus_rd(12'h400, r); check("R2 readback", r, 8'hA5);

    // R5 write to input pin ignored, then switch to output
    bus_wr(12'h400, 8'h00);
    bus_wr(12'h3FC, 8'hFF); check("R5 input write", pad_out, 8'h00);
    bus_wr(12'h400, 8'h01); check("R5 after switch", pad_out, 8'h00);
    bus_wr(12'h004, 8'h01); check("R5 rewrite", pad_out, 8'h01);

    // R3 masked write: only pin 3 (addr bit 5) of output pins
    bus_wr(12'h400, 8'hFF);
    bus_wr(12'h020, 8'hFF); check("R3 single pin", pad_out, 8'h09);
    bus_wr(12'h000, 8'h00); check("R3 zero mask", pad_out, 8'h09);

    // R4 masked read mixing directions
    bus_wr(12'h400, 8'h0F);
    set_pad(8'hF0);
    bus_rd(12'h3FC, r); check("R4 full", r, f_data_read(12'h3FC));
    bus_rd(12'h0C0, r); check("R4 partial", r, f_data_read(12'h0C0));

    // R6 level high on pin 0, clear has no effect
    set_pad(8'h00);
    bus_wr(12'h404, 8'h01); bus_wr(12'h40C, 8'h01); bus_wr(12'h410, 8'h01);
    set_pad(8'h01); check_irq("R6 level high");
    check("R6 irq", {7'd0, irq_out}, 8'h01);
    bus_wr(12'h41C, 8'hFF); check_irq("R6 clear ignored");
    bus_rd(12'h414, r); check("R6 still set", r, 8'h01);
    set_pad(8'h00); check_irq("R6 follows");
    bus_rd(12'h414, r); check("R6 dropped", r, 8'h00);

    // R7 rising on pin 1, falling on pin 2
    bus_wr(12'h404, 8'h00); bus_wr(12'h40C, 8'h02); bus_wr(12'h410, 8'h06);
    bus_wr(12'h41C, 8'hFF);
    set_pad(8'h06); bus_rd(12'h414, r); check("R7 rise only", r, 8'h02);
    set_pad(8'h00); bus_rd(12'h414, r); check("R7 both latched", r, 8'h06);
    check_irq("R10 masked");

    // R9 clear with zeros then ones
    bus_wr(12'h41C, 8'h00); bus_rd(12'h414, r); check("R9 zero write", r, 8'h06);
    bus_wr(12'h41C, 8'h02); bus_rd(12'h414, r); check("R9 clear one", r, 8'h04);

    // R8 both edges with polarity set to rising, falling edge must trigger
    bus_wr(12'h41C, 8'hFF);
    bus_wr(12'h408, 8'h10); bus_wr(12'h40C, 8'h10);
    set_pad(8'h10); bus_wr(12'h41C, 8'hFF);
    set_pad(8'h00); bus_rd(12'h414, r); check("R8 falling", r, 8'h10);

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: bus_wr(12'h400 + 12'(4 * $urandom_range(0, 4)), 8'($urandom));
        1, 2: set_pad(8'($urandom));
        3: bus_wr({2'b00, 8'($urandom), 2'b00}, 8'($urandom));
        4: bus_wr(12'h41C, 8'($urandom));
        default: bus_wr(12'h410, 8'($urandom));
      endcase
      check("R3 pad_out", pad_out, m_data);
      check("R2 pad_oe", pad_oe, m_dir);
      a = {2'b00, 8'($urandom), 2'b00};
      bus_rd(a, r); check("R4 random read", r, f_data_read(a));
      check_irq("R10 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule